// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block is the master-side sequencer of an I2C peripheral. Software raises a start request. The block then waits until the bus is free, issues a START, and parks with SCL held low. Each write strobe then moves one byte across the bus: eight data bits, MSB first, followed by one acknowledge slot. A stop request ends the transaction with a STOP. The SCL timing comes from the system clock: every timed step lasts `scaler + 1` system clocks. SCL and SDA are open-drain: an output of 1 pulls the line low, and a 0 releases it to the pull-up.

The FSM has these states:
- `ST_IDLE`: the bus is released.
- `ST_START_A`: SDA is low and SCL is high.
- `ST_START_B`: both lines are low.
- `ST_HOLD`: SCL is low, waiting for a byte command or a stop.
- `ST_BIT_LO` and `ST_BIT_HI`: the low and high halves of a data bit.
- `ST_ACK_LO` and `ST_ACK_HI`: the low and high halves of the acknowledge slot.
- `ST_STOP_A` (both lines low), `ST_STOP_B` (SCL high, SDA low) and `ST_STOP_C` (both released, bus free time).

The FSM takes these transitions:
- IDLE goes to START_A when a start is requested and the bus is free.
- START_A goes to START_B, and START_B goes to HOLD.
- HOLD goes to BIT_LO on a write strobe, or to STOP_A when a stop is pending.
- BIT_LO goes to BIT_HI.
- BIT_HI goes back to BIT_LO, or to ACK_LO after the last bit.
- ACK_LO goes to ACK_HI, and ACK_HI goes back to HOLD.
- STOP_A goes to STOP_B, STOP_B goes to STOP_C, and STOP_C goes to IDLE.
- Every transition between timed states happens on the half-period tick.
- Any state goes to IDLE when the block is disabled or in slave role.

The two request flags are also status. The start flag stays set until the STOP it belongs to has finished. The stop flag stays set until the next START has finished.

Top module: `i2cm_master`

## Requirements
- R1: After reset both line enables are 0, both flags are 0, `byte_done` is 0 and `ack_bit` is 1.
- R2: A start request with the bus free drives SDA low while SCL is high for `scaler+1` clocks, then pulls SCL low. The stop flag clears when this START completes.
- R3: While the bus is busy, the block does not start. The bus becomes busy when SDA falls while SCL is high, and becomes free when SDA rises while SCL is high. The pending start proceeds once a STOP is seen.
- R4: Every SCL high phase and every SCL low phase of a data or acknowledge bit lasts `scaler+1` clocks.
- R5: In transmit mode (`rx_mode`=0), the block sends `wr_data` MSB first and releases SDA in the acknowledge slot. `ack_bit` then holds the sampled SDA level: 0 means ACK, 1 means NACK.
- R6: In receive mode (`rx_mode`=1), SDA is released during the data bits and `rx_byte` holds the bits sampled MSB first. In the acknowledge slot, SDA is pulled low (ACK) when `last_byte`=0 and released (NACK) when `last_byte`=1.
- R7: `byte_done` pulses for exactly one cycle after the acknowledge slot of each byte.
- R8: A stop request in HOLD releases SCL, then SDA. The start flag clears when the STOP completes, and the stop flag stays 1.
- R9: With `en`=0, both flags clear, both lines are released, the FSM returns to IDLE and the bus-busy view is reset.
- R10: With `master_sel`=0, the block leaves the bus untouched. A start request is held and proceeds once `master_sel` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Module enable; 0 clears flags and idles |
| master_sel | input | 1 | 1 = master role (active), 0 = slave role (inactive) |
| rx_mode | input | 1 | Byte direction, sampled with the write strobe: 1 = receive |
| last_byte | input | 1 | 1 = NACK after the received byte |
| start_set | input | 1 | One-cycle pulse that sets the start flag |
| stop_set | input | 1 | One-cycle pulse that sets the stop flag |
| scaler | input | SCW | Half-period setting; each phase is scaler+1 clocks |
| wr_data | input | DW | Address or data byte to send |
| wr_strobe | input | 1 | Begins one byte transfer from HOLD |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| start_flag | output | 1 | Start request / bus-owned status |
| stop_flag | output | 1 | Stop request / stopped status |
| byte_done | output | 1 | One-cycle pulse after each acknowledge slot |
| ack_bit | output | 1 | Acknowledge level from the slave, 0 = ACK |
| rx_byte | output | DW | Shift register contents; the received byte after byte_done |

## Verification
A table of transactions is used, and each one mixes a different `scaler` with a direction and a data byte. The edge values cover an alternating pattern, all ones, a lone LSB, a lone MSB and the zero scaler with one-cycle phases. Sending and receiving the same kind of byte separates bit order from drive direction. Pairing ACK with NACK in each direction shows that the slave's acknowledge and the master's `last_byte` choice each reach the right place. Measured START hold, SCL high and SCL low widths at several scaler values separate a correct `scaler+1` count from an off-by-one.

Directed runs cover four cases: an external START that keeps the bus busy, the slave role holding a request, a disable in the middle of a byte, and the reset state.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START_A,
        ST_START_B,
        ST_HOLD,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_STOP_A,
        ST_STOP_B,
        ST_STOP_C
    } i2cm_state_e;

endpackage

// File: rtl/i2cm_halfper.sv
// Half-period timer: tick is high in the last clock of a phase that lasts
// limit+1 clocks; restart starts a new phase.
module i2cm_halfper #(
    parameter int SCW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           restart,
    input  logic [SCW-1:0] limit,
    output logic           tick
);

    logic [SCW-1:0] cnt_q;

    assign tick = (cnt_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/i2cm_busmon.sv
// Bus-free monitor: a START on the lines marks the bus busy, a STOP frees it.
module i2cm_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic scl_in,
    input  logic sda_in,
    output logic busy
);

    logic scl_q, sda_q;
    logic start_seen, stop_seen;

    assign start_seen = scl_q && scl_in && sda_q && !sda_in;
    assign stop_seen  = scl_q && scl_in && !sda_q && sda_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            busy  <= 1'b0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (!en || stop_seen)
                busy <= 1'b0;
            else if (start_seen)
                busy <= 1'b1;
        end
    end

endmodule

// File: rtl/i2cm_master.sv
module i2cm_master
    import i2cm_pkg::*;
#(
    parameter int DW  = 8,
    parameter int SCW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           master_sel,
    input  logic           rx_mode,
    input  logic           last_byte,
    input  logic           start_set,
    input  logic           stop_set,
    input  logic [SCW-1:0] scaler,
    input  logic [DW-1:0]  wr_data,
    input  logic           wr_strobe,
    input  logic           scl_in,
    input  logic           sda_in,
    output logic           scl_oe,
    output logic           sda_oe,
    output logic           start_flag,
    output logic           stop_flag,
    output logic           byte_done,
    output logic           ack_bit,
    output logic [DW-1:0]  rx_byte
);

    localparam int              BCW      = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [BCW-1:0]  LAST_BIT = BCW'(DW - 1);

    i2cm_state_e    state_q, state_d;
    logic           tick, busy, active;
    logic           hold_go, bit_end, ack_end, start_end, stop_end;
    logic [DW-1:0]  shreg_q;
    logic [BCW-1:0] bitcnt_q;
    logic           dir_q, last_q, done_q, ack_q;

    assign active    = en && master_sel;
    assign hold_go   = active && (state_q == ST_HOLD) && wr_strobe;
    assign bit_end   = active && (state_q == ST_BIT_HI) && tick;
    assign ack_end   = active && (state_q == ST_ACK_HI) && tick;
    assign start_end = active && (state_q == ST_START_B) && tick;
    assign stop_end  = active && (state_q == ST_STOP_C) && tick;

    i2cm_halfper #(.SCW(SCW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .limit   (scaler),
        .tick    (tick)
    );

    i2cm_busmon u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .busy   (busy)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!active) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:    if (start_flag && !busy) state_d = ST_START_A;
                ST_START_A: if (tick) state_d = ST_START_B;
                ST_START_B: if (tick) state_d = ST_HOLD;
                ST_HOLD: begin
                    if (wr_strobe)      state_d = ST_BIT_LO;
                    else if (stop_flag) state_d = ST_STOP_A;
                end
                ST_BIT_LO:  if (tick) state_d = ST_BIT_HI;
                ST_BIT_HI:  if (tick) state_d = (bitcnt_q == LAST_BIT) ? ST_ACK_LO : ST_BIT_LO;
                ST_ACK_LO:  if (tick) state_d = ST_ACK_HI;
                ST_ACK_HI:  if (tick) state_d = ST_HOLD;
                ST_STOP_A:  if (tick) state_d = ST_STOP_B;
                ST_STOP_B:  if (tick) state_d = ST_STOP_C;
                ST_STOP_C:  if (tick) state_d = ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request flags and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_flag <= 1'b0;
            stop_flag  <= 1'b0;
            shreg_q    <= '0;
            bitcnt_q   <= '0;
            dir_q      <= 1'b0;
            last_q     <= 1'b0;
            done_q     <= 1'b0;
            ack_q      <= 1'b1;
        end else begin
            if (!en)            start_flag <= 1'b0;
            else if (start_set) start_flag <= 1'b1;
            else if (stop_end)  start_flag <= 1'b0;

            if (!en)            stop_flag <= 1'b0;
            else if (stop_set)  stop_flag <= 1'b1;
            else if (start_end) stop_flag <= 1'b0;

            done_q <= ack_end;

            if (hold_go) begin
                shreg_q  <= wr_data;
                bitcnt_q <= '0;
                dir_q    <= rx_mode;
            end else if (bit_end) begin
                shreg_q  <= {shreg_q[DW-2:0], sda_in};
                bitcnt_q <= bitcnt_q + 1'b1;
                if (bitcnt_q == LAST_BIT) last_q <= last_byte;
            end

            if (ack_end && !dir_q) ack_q <= sda_in;
        end
    end

    // Line drive per state
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_STOP_C: ;
            ST_START_A, ST_STOP_B:    sda_oe = 1'b1;
            ST_START_B, ST_STOP_A: begin
                scl_oe = 1'b1;
                sda_oe = 1'b1;
            end
            ST_HOLD:   scl_oe = 1'b1;
            ST_BIT_LO: begin
                scl_oe = 1'b1;
                sda_oe = !dir_q && !shreg_q[DW-1];
            end
            ST_BIT_HI: sda_oe = !dir_q && !shreg_q[DW-1];
            ST_ACK_LO: begin
                scl_oe = 1'b1;
                sda_oe = dir_q && !last_q;
            end
            ST_ACK_HI: sda_oe = dir_q && !last_q;
            default: ;
        endcase
    end

    assign byte_done = done_q;
    assign ack_bit   = ack_q;
    assign rx_byte   = shreg_q;

endmodule

// File: rtl/i2cm_master_chk.sv
module i2cm_master_chk
    import i2cm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        master_sel,
    input logic        scl_oe,
    input logic        sda_oe,
    input logic        start_flag,
    input logic        stop_flag,
    input logic        byte_done,
    input logic        bus_busy,
    input i2cm_state_e state
);

    // R9: disabling releases the lines and clears both flags
    p_disable_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_oe && !sda_oe && !start_flag && !stop_flag));

    // R10: slave role leaves the bus alone
    p_slave_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !master_sel |=> (!scl_oe && !sda_oe));

    // R7: byte_done never lasts two cycles
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    // R3: SDA is only pulled low under a released SCL when the bus was free
    p_start_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe) |-> !$past(bus_busy));

    // R2: SCL is only driven while the bus is owned
    p_owner_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> start_flag);

    // R8: the start flag falls only on STOP completion or disable
    p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_flag) |-> ($past(!en) || $past(state == ST_STOP_C)));

    // R2: the stop flag falls only on START completion or disable
    p_stop_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stop_flag) |-> ($past(!en) || $past(state == ST_START_B)));

endmodule

bind i2cm_master i2cm_master_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .master_sel (master_sel),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .start_flag (start_flag),
    .stop_flag  (stop_flag),
    .byte_done  (byte_done),
    .bus_busy   (busy),
    .state      (state_q)
);

// File: tb/sim_i2cm_master.sv
`timescale 1ns/1ps
module sim_i2cm_master;

    logic clk = 1'b0;
    logic rst_n, en, master_sel, rx_mode, last_byte, start_set, stop_set, wr_strobe;
    logic [7:0] scaler, wr_data, rx_byte;
    logic scl_in, sda_in, scl_oe, sda_oe, start_flag, stop_flag, byte_done, ack_bit;
    logic ext_sda_low = 1'b0;

    int checks = 0, fails = 0, cyc = 0;
    int fcnt = 0, base = 0;
    logic sl_on = 1'b0, sl_rx = 1'b0, sl_ack = 1'b0, sl_sda_low;
    logic [7:0] sl_byte = 8'h00, cap = 8'h00;
    logic mack = 1'b1, stop_seen = 1'b0;
    logic prev_scl = 1'b1, prev_sda = 1'b1;
    time t_rise = 0, t_fall = 0, t_sfall = 0, hi_w = 0, lo_w = 0, st_w = 0;

    // {scaler[7:0], rx, last, slave_ack, data[7:0]}
    localparam logic [18:0] VECS [6] = '{
        {8'd3, 1'b0, 1'b0, 1'b1, 8'hA5},
        {8'd0, 1'b0, 1'b0, 1'b0, 8'h3C},
        {8'd5, 1'b1, 1'b0, 1'b0, 8'h96},
        {8'd1, 1'b1, 1'b1, 1'b0, 8'h01},
        {8'd2, 1'b0, 1'b0, 1'b1, 8'hFF},
        {8'd4, 1'b1, 1'b0, 1'b0, 8'h80}
    };

    always #5 clk = ~clk;

    i2cm_master u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .master_sel(master_sel),
        .rx_mode(rx_mode), .last_byte(last_byte), .start_set(start_set),
        .stop_set(stop_set), .scaler(scaler), .wr_data(wr_data),
        .wr_strobe(wr_strobe), .scl_in(scl_in), .sda_in(sda_in),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .start_flag(start_flag),
        .stop_flag(stop_flag), .byte_done(byte_done), .ack_bit(ack_bit),
        .rx_byte(rx_byte)
    );

    // Wired-AND bus with pull-ups; bench slave drives by SCL fall count
    assign sl_sda_low = sl_on && (
        (sl_rx && (fcnt - base) >= 0 && (fcnt - base) < 8 && !sl_byte[7 - (fcnt - base)]) ||
        (!sl_rx && (fcnt - base) == 8 && sl_ack));
    assign scl_in = !scl_oe;
    assign sda_in = !(sda_oe || sl_sda_low || ext_sda_low);

    always @(scl_in or sda_in) begin
        if (prev_scl && !scl_in) begin
            if (fcnt == 0) st_w = $time - t_sfall;
            fcnt = fcnt + 1;
            hi_w = $time - t_rise;
            t_fall = $time;
        end else if (!prev_scl && scl_in) begin
            lo_w = $time - t_fall;
            t_rise = $time;
            if (sl_on && (fcnt - base) >= 0 && (fcnt - base) < 8) cap = {cap[6:0], sda_in};
            if (sl_on && (fcnt - base) == 8) mack = sda_in;
        end else if (scl_in && prev_sda && !sda_in) begin
            fcnt = 0;
            t_sfall = $time;
        end else if (scl_in && !prev_sda && sda_in) begin
            stop_seen = 1'b1;
        end
        prev_scl = scl_in;
        prev_sda = sda_in;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            fails++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic pulse_start();
        @(negedge clk) start_set = 1'b1;
        @(negedge clk) start_set = 1'b0;
    endtask

    // Wait for a START to finish and check it (R2)
    task automatic see_start(input int s);
        bit got = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (fcnt == 1 && !scl_in) begin got = 1; break; end
        end
        chk(got, "R2 start issued", got, 1);
        repeat (s + 3) @(negedge clk);
        chk(st_w == (s + 1) * 10, "R2 start hold width", st_w, (s + 1) * 10);
        chk(!stop_flag && start_flag, "R2 flags after start", {stop_flag, start_flag}, 2'b01);
    endtask

    task automatic do_stop();
        bit got = 0;
        stop_seen = 1'b0;
        @(negedge clk) stop_set = 1'b1;
        @(negedge clk) stop_set = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (!start_flag) begin got = 1; break; end
            @(negedge clk);
        end
        chk(got, "R8 start flag cleared by stop", start_flag, 0);
        chk(stop_flag == 1'b1, "R8 stop flag held", stop_flag, 1);
        chk(stop_seen && scl_in && sda_in, "R8 stop on bus", {stop_seen, scl_in, sda_in}, 3'b111);
    endtask

    task automatic xfer(input int s, input bit rx, input bit last, input bit ak, input logic [7:0] d);
        bit got = 0;
        base = fcnt; sl_rx = rx; sl_byte = d; sl_ack = ak; sl_on = 1'b1;
        @(negedge clk) begin
            rx_mode = rx; last_byte = last; wr_data = rx ? 8'h00 : d; wr_strobe = 1'b1;
        end
        @(negedge clk) wr_strobe = 1'b0;
        for (int i = 0; i < 600; i++) begin
            if (byte_done) begin got = 1; break; end
            @(negedge clk);
        end
        chk(got, "R7 byte_done seen", got, 1);
        if (rx) begin
            chk(rx_byte == d, "R6 received byte", rx_byte, d);
            chk(mack == last, "R6 master ack level", mack, last);
        end else begin
            chk(cap == d, "R5 transmitted byte", cap, d);
            chk(ack_bit == !ak, "R5 ack_bit", ack_bit, !ak);
        end
        chk(hi_w == (s + 1) * 10, "R4 SCL high width", hi_w, (s + 1) * 10);
        chk(lo_w == (s + 1) * 10, "R4 SCL low width", lo_w, (s + 1) * 10);
        @(negedge clk);
        chk(!byte_done, "R7 byte_done one cycle", byte_done, 0);
        sl_on = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b1; master_sel = 1'b1; rx_mode = 1'b0; last_byte = 1'b0;
        start_set = 1'b0; stop_set = 1'b0; wr_strobe = 1'b0; scaler = 8'd3; wr_data = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
        chk(!start_flag && !stop_flag && !byte_done && ack_bit, "R1 flags",
            {start_flag, stop_flag, byte_done, ack_bit}, 4'b0001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table of transactions
        for (int v = 0; v < 6; v++) begin
            int s;
            s = int'(VECS[v][18:11]);
            scaler = VECS[v][18:11];
            pulse_start();
            see_start(s);
            xfer(s, VECS[v][10], VECS[v][9], VECS[v][8], VECS[v][7:0]);
            do_stop();
            repeat (4) @(negedge clk);
        end

        // R3: external START keeps the bus busy
        scaler = 8'd2;
        @(negedge clk) ext_sda_low = 1'b1;
        repeat (3) @(negedge clk);
        pulse_start();
        repeat (20) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R3 no start while busy", {scl_oe, sda_oe}, 0);
        chk(start_flag, "R3 request held while busy", start_flag, 1);
        @(negedge clk) ext_sda_low = 1'b0;
        see_start(2);
        do_stop();
        repeat (4) @(negedge clk);

        // R10: slave role holds the request without touching the bus
        master_sel = 1'b0;
        pulse_start();
        repeat (20) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R10 slave role quiet", {scl_oe, sda_oe}, 0);
        chk(start_flag, "R10 request held", start_flag, 1);
        master_sel = 1'b1;
        see_start(2);
        do_stop();
        repeat (4) @(negedge clk);

        // R9: disable in the middle of a byte
        pulse_start();
        see_start(2);
        base = fcnt;
        @(negedge clk) begin rx_mode = 1'b0; wr_data = 8'h00; wr_strobe = 1'b1; end
        @(negedge clk) wr_strobe = 1'b0;
        @(negedge clk) stop_set = 1'b1;
        @(negedge clk) stop_set = 1'b0;
        repeat (4) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        chk(!scl_oe && !sda_oe, "R9 lines released", {scl_oe, sda_oe}, 0);
        chk(!start_flag && !stop_flag, "R9 flags cleared", {start_flag, stop_flag}, 0);
        en = 1'b1;
        repeat (10) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R9 stays idle", {scl_oe, sda_oe}, 0);

        finish_run();
    end

endmodule